// File: doc/BRIEF.md
# Shared Bus Arbiter with Split Masking

This block decides which of several bus masters owns the address and control phase of a shared, pipelined system bus. Each master raises its own request line. The arbiter returns a one-hot grant vector, which is the select for the address and control multiplexer. It also returns the same choice as a 4-bit binary master number. The master number lets a slave record which master it has put on hold. Grant changes happen only at the end of an address phase, which is a clock edge with ready high.

A run-time input selects the priority order, either fixed or round-robin. A master that drives its lock request keeps the bus for its whole locked sequence. It then keeps the bus for one more real transfer, and slaves see a lock indication for this whole span. When a slave answers with a two-cycle split response, the master in the data phase is put on hold. It takes no part in arbitration until a slave sets that master's bit in the resume vector. A retry response changes nothing in the arbiter. When no master is eligible, master 0 is granted as the default owner and drives idle transfers.

Top module: `shared_bus_arbiter`

## Requirements
- R1: Reset is active-low and asynchronous. While it is low, grant is 0...01, master_id is 0 and master_lock is 0. All split holds are cleared.
- R2: grant and master_id change only on a rising clock edge where ready is 1. On any edge with ready 0 they keep their value.
- R3: With rr_mode 0, the eligible requester with the lowest index wins. A master is eligible when its req bit is 1 and it is not on split hold.
- R4: With rr_mode 1, the search starts at the master one above the currently granted master and wraps past the highest index to 0. The first eligible requester found wins.
- R5: When no master is eligible at an arbitration edge, master 0 is granted.
- R6: grant is one-hot. Its set bit is at the position given by master_id, a 4-bit unsigned number.
- R7: On a ready edge where the granted master's lock_req bit is 1, that master keeps the grant. This holds even when a higher-priority master is requesting. master_lock is 1 while the granted master's lock_req bit is 1.
- R8: After the granted master drops lock_req, the grant is held until one more ready edge has passed with trans equal to NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00) and BUSY (2'b01) edges do not count. master_lock stays 1 until that transfer has been counted.
- R9: A SPLIT response is resp 2'b11 seen with ready 0. It puts on hold the master whose address phase ended at the latest ready edge. From the next arbitration on, that master is skipped, so a lower-priority requester can win.
- R10: A held master's hold is cleared at a clock edge where its split_resume bit is 1. It can win arbitration from the following ready edge.
- R11: A RETRY response (resp 2'b10) sets no hold. Arbitration continues as normal, so the same master can win again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_mode | input | 1 | 0 = fixed priority, 1 = round-robin |
| req | input | N_MASTERS | Per-master bus request |
| lock_req | input | N_MASTERS | Per-master locked-sequence request |
| trans | input | 2 | Current transfer type (IDLE 00, BUSY 01, NONSEQ 10, SEQ 11) |
| ready | input | 1 | Bus ready; 1 ends the current address phase |
| resp | input | 2 | Slave response (OKAY 00, ERROR 01, RETRY 10, SPLIT 11) |
| split_resume | input | N_MASTERS | Per-master resume from slaves, clears a split hold |
| grant | output | N_MASTERS | One-hot grant, the select for the address and control multiplexer |
| master_id | output | 4 | Binary number of the granted master |
| master_lock | output | 1 | A locked sequence is in force for the granted master |

## Verification
In fixed mode, the stimulus uses sparse request sets, an empty set and a stalled edge. These separate lowest-index selection, the fallback to master 0 and holding the grant while ready is low. In round-robin mode, every master requests at once, and then a gapped set is used. This shows the rotation starts one above the owner and wraps, which fixed priority would never produce. Locked sequences run once with active transfer types and once with IDLE cycles inserted after the lock drops. This shows that only real transfers use up the extra held transfer. A split and a retry are each applied with the same higher-priority master requesting. The split lets a lower master through and keeps the held master out until its resume bit, while the retry lets the same master win again. A reset in mid-run shows that a pending hold is discarded.

// File: rtl/arb_pkg.sv
package arb_pkg;

   // transfer type seen on the bus
   typedef enum logic [1:0] {
      TR_IDLE = 2'b00,
      TR_BUSY = 2'b01,
      TR_NSEQ = 2'b10,
      TR_SEQ  = 2'b11
   } xfer_t;

   // slave response code
   typedef enum logic [1:0] {
      RS_OKAY  = 2'b00,
      RS_ERROR = 2'b01,
      RS_RETRY = 2'b10,
      RS_SPLIT = 2'b11
   } resp_t;

   localparam int MID_W   = 4;
   localparam int MAX_MST = 16;

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  eligible,
   input  logic [IW-1:0] last_id,
   input  logic          rr_mode,
   output logic          found,
   output logic [IW-1:0] win_id
);

   // lowest index wins
   function automatic logic [IW:0] pick_fixed(input logic [N-1:0] e);
      logic [IW:0] r;
      r = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (e[i]) r = {1'b1, IW'(i)};
      end
      return r;
   endfunction

   // first eligible index at or after last+1, wrapping
   function automatic logic [IW:0] pick_rot(input logic [N-1:0] e,
                                            input logic [IW-1:0] last);
      logic [IW:0] r;
      int          start;
      int          idx;
      r     = '0;
      start = int'(last) + 1;
      if (start >= N) start = 0;
      for (int k = N - 1; k >= 0; k--) begin
         idx = start + k;
         if (idx >= N) idx = idx - N;
         if (e[idx]) r = {1'b1, IW'(idx)};
      end
      return r;
   endfunction

   logic [IW:0] res_fix;
   logic [IW:0] res_rot;
   logic [IW:0] res_sel;

   always_comb begin
      res_fix = pick_fixed(eligible);
      res_rot = pick_rot(eligible, last_id);
      res_sel = rr_mode ? res_rot : res_fix;
      found   = res_sel[IW];
      win_id  = res_sel[IW-1:0];
   end

endmodule

// File: rtl/arb_split_mask.sv
module arb_split_mask
   import arb_pkg::*;
#(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ready,
   input  logic [1:0]    resp,
   input  logic [IW-1:0] dph_id,
   input  logic [N-1:0]  split_resume,
   output logic [N-1:0]  mask
);

   resp_t       rs;
   logic        split_hit;
   logic [N-1:0] set_vec;

   assign rs        = resp_t'(resp);
   assign split_hit = (rs == RS_SPLIT) && !ready;

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_set
         assign set_vec[g] = split_hit && (dph_id == IW'(g));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask <= '0;
      else        mask <= (mask & ~split_resume) | set_vec;
   end

   // R9
   split_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rs == RS_SPLIT) && !ready) |=> mask[$past(dph_id)]);

   // R11
   retry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rs == RS_RETRY) && (split_resume == '0)) |=> $stable(mask));

   generate
      for (g = 0; g < N; g++) begin : g_clr
         // R10
         resume_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (split_resume[g] && !(split_hit && (dph_id == IW'(g)))) |=> !mask[g]);
      end
   endgenerate

endmodule

// File: rtl/arb_grant_dec.sv
module arb_grant_dec #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [IW-1:0] id,
   output logic [N-1:0]  grant
);

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_dec
         assign grant[g] = (id == IW'(g));
      end
   endgenerate

endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter
   import arb_pkg::*;
#(
   parameter int N_MASTERS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rr_mode,
   input  logic [N_MASTERS-1:0] req,
   input  logic [N_MASTERS-1:0] lock_req,
   input  logic [1:0]           trans,
   input  logic                 ready,
   input  logic [1:0]           resp,
   input  logic [N_MASTERS-1:0] split_resume,
   output logic [N_MASTERS-1:0] grant,
   output logic [MID_W-1:0]     master_id,
   output logic                 master_lock
);

   localparam int IW = $clog2(N_MASTERS);

   generate
      if (N_MASTERS < 2 || N_MASTERS > MAX_MST) begin : g_bad_cfg
         $error("shared_bus_arbiter: N_MASTERS must be in 2..16");
      end
   endgenerate

   logic [IW-1:0]        gid_q;
   logic [IW-1:0]        dph_q;
   logic                 lk_q;
   logic [N_MASTERS-1:0] mask;
   logic [N_MASTERS-1:0] eligible;
   logic                 found;
   logic [IW-1:0]        win_id;
   logic                 cur_lock;
   logic                 active;
   xfer_t                xt;

   assign xt       = xfer_t'(trans);
   assign active   = (xt == TR_NSEQ) || (xt == TR_SEQ);
   assign cur_lock = lock_req[gid_q];
   assign eligible = req & ~mask;

   arb_prio_pick #(.N(N_MASTERS), .IW(IW)) u_pick (
      .eligible (eligible),
      .last_id  (gid_q),
      .rr_mode  (rr_mode),
      .found    (found),
      .win_id   (win_id)
   );

   arb_split_mask #(.N(N_MASTERS), .IW(IW)) u_mask (
      .clk          (clk),
      .rst_n        (rst_n),
      .ready        (ready),
      .resp         (resp),
      .dph_id       (dph_q),
      .split_resume (split_resume),
      .mask         (mask)
   );

   arb_grant_dec #(.N(N_MASTERS), .IW(IW)) u_dec (
      .id    (gid_q),
      .grant (grant)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gid_q <= '0;
         dph_q <= '0;
         lk_q  <= 1'b0;
      end else if (ready) begin
         dph_q <= gid_q;
         if (cur_lock) begin
            lk_q <= 1'b1;
         end else if (lk_q) begin
            if (active) lk_q <= 1'b0;
         end else begin
            gid_q <= found ? win_id : '0;
         end
      end
   end

   assign master_id   = MID_W'(gid_q);
   assign master_lock = cur_lock | lk_q;

   // R2
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> $stable(master_id));

   // R7
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && lock_req[gid_q]) |=> ($stable(master_id) && master_lock));

   // R6
   grant_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(grant) && grant[master_id[IW-1:0]]);

   // R5
   idle_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !lock_req[gid_q] && !lk_q && ((req & ~mask) == '0))
         |=> (master_id == '0));

endmodule

// File: tb/shared_bus_arbiter_tb.sv
`timescale 1ns/1ps
module shared_bus_arbiter_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rr_mode = 1'b0;
   logic [3:0] req = '0;
   logic [3:0] lock_req = '0;
   logic [1:0] trans = 2'b00;
   logic       ready = 1'b1;
   logic [1:0] resp = 2'b00;
   logic [3:0] split_resume = '0;
   logic [3:0] grant;
   logic [3:0] master_id;
   logic       master_lock;

   typedef struct {
      int    id;
      bit    lk;
      string tag;
   } exp_t;

   exp_t sbq[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   shared_bus_arbiter #(.N_MASTERS(4)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .rr_mode      (rr_mode),
      .req          (req),
      .lock_req     (lock_req),
      .trans        (trans),
      .ready        (ready),
      .resp         (resp),
      .split_resume (split_resume),
      .grant        (grant),
      .master_id    (master_id),
      .master_lock  (master_lock)
   );

   task automatic chk(input string tag, input int id, input bit lk);
      logic [3:0] eg;
      eg = 4'b0001 << id;
      n_cmp++;
      if (master_id !== 4'(id) || grant !== eg || master_lock !== lk) begin
         n_bad++;
         $display("FAIL %s: id=%0d grant=%b lock=%b expected id=%0d grant=%b lock=%b",
                  tag, master_id, grant, master_lock, id, eg, lk);
      end
   endtask

   // driver: applies one cycle of stimulus and queues the expected result
   task automatic step(input logic [3:0] rq, input logic [3:0] lk,
                       input logic [1:0] tr, input logic rdy,
                       input logic [1:0] rs, input logic [3:0] rsm,
                       input logic rr, input int eid, input bit elk,
                       input string tag);
      exp_t e;
      @(negedge clk);
      req = rq; lock_req = lk; trans = tr; ready = rdy;
      resp = rs; split_resume = rsm; rr_mode = rr;
      e.id = eid; e.lk = elk; e.tag = tag;
      sbq.push_back(e);
   endtask

   // monitor: compares after each edge, away from the edge
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #2;
         if (sbq.size() > 0) begin
            e = sbq.pop_front();
            chk(e.tag, e.id, e.lk);
         end
      end
   end

   initial begin
      #25000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   localparam logic [1:0] IDL = 2'b00, NSQ = 2'b10;
   localparam logic [1:0] OK = 2'b00, RTY = 2'b10, SPL = 2'b11;

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1 reset state", 0, 1'b0);
      rst_n = 1'b1;

      // fixed priority
      step(4'b0110, 4'b0000, NSQ, 1, OK, 4'b0000, 0, 1, 0, "R3 lowest wins");
      step(4'b1000, 4'b0000, NSQ, 1, OK, 4'b0000, 0, 3, 0, "R3 single req");
      step(4'b0000, 4'b0000, IDL, 1, OK, 4'b0000, 0, 0, 0, "R5 no request");
      step(4'b0100, 4'b0000, NSQ, 0, OK, 4'b0000, 0, 0, 0, "R2 stall holds");
      step(4'b0100, 4'b0000, NSQ, 1, OK, 4'b0000, 0, 2, 0, "R2 change on ready");
      // round-robin
      step(4'b1111, 4'b0000, NSQ, 1, OK, 4'b0000, 1, 3, 0, "R4 after 2");
      step(4'b1111, 4'b0000, NSQ, 1, OK, 4'b0000, 1, 0, 0, "R4 wrap");
      step(4'b1111, 4'b0000, NSQ, 1, OK, 4'b0000, 1, 1, 0, "R4 rotate");
      step(4'b1010, 4'b0000, NSQ, 1, OK, 4'b0000, 1, 3, 0, "R4 gap skip");
      // locked sequence, active transfers
      step(4'b0010, 4'b0010, NSQ, 1, OK, 4'b0000, 0, 1, 1, "R7 lock owner");
      step(4'b0011, 4'b0010, NSQ, 1, OK, 4'b0000, 0, 1, 1, "R7 lock excludes 0");
      step(4'b0001, 4'b0000, NSQ, 1, OK, 4'b0000, 0, 1, 0, "R8 extra transfer");
      step(4'b0001, 4'b0000, NSQ, 1, OK, 4'b0000, 0, 0, 0, "R8 released");
      // locked sequence with idle after lock drop
      step(4'b0100, 4'b0100, NSQ, 1, OK, 4'b0000, 0, 2, 1, "R7 lock owner 2");
      step(4'b0101, 4'b0100, NSQ, 1, OK, 4'b0000, 0, 2, 1, "R7 hold 2");
      step(4'b0001, 4'b0000, IDL, 1, OK, 4'b0000, 0, 2, 1, "R8 idle not counted");
      step(4'b0001, 4'b0000, NSQ, 1, OK, 4'b0000, 0, 2, 0, "R8 counted");
      step(4'b0001, 4'b0000, NSQ, 1, OK, 4'b0000, 0, 0, 0, "R8 released 2");
      // split
      step(4'b0110, 4'b0000, NSQ, 1, OK, 4'b0000, 0, 1, 0, "R3 pre split");
      step(4'b0110, 4'b0000, NSQ, 1, OK, 4'b0000, 0, 1, 0, "R3 pre split 2");
      step(4'b0110, 4'b0000, NSQ, 0, SPL, 4'b0000, 0, 1, 0, "R9 split cycle 1");
      step(4'b0110, 4'b0000, NSQ, 1, SPL, 4'b0000, 0, 2, 0, "R9 lower wins");
      step(4'b0010, 4'b0000, NSQ, 1, OK, 4'b0000, 0, 0, 0, "R9 masked default");
      step(4'b0010, 4'b0000, NSQ, 1, OK, 4'b0010, 0, 0, 0, "R10 resume edge");
      step(4'b0010, 4'b0000, NSQ, 1, OK, 4'b0000, 0, 1, 0, "R10 eligible again");
      // retry
      step(4'b0010, 4'b0000, NSQ, 1, OK, 4'b0000, 0, 1, 0, "R11 setup");
      step(4'b0010, 4'b0000, NSQ, 0, RTY, 4'b0000, 0, 1, 0, "R11 retry cycle 1");
      step(4'b0110, 4'b0000, NSQ, 1, RTY, 4'b0000, 0, 1, 0, "R11 same wins");
      // split hold then async reset clears it
      step(4'b0010, 4'b0000, NSQ, 0, SPL, 4'b0000, 0, 1, 0, "R9 split before reset");
      wait (sbq.size() == 0);
      @(negedge clk);
      rst_n = 1'b0;
      ready = 1'b0; resp = OK; req = '0;
      #1;
      chk("R1 async reset", 0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      step(4'b0010, 4'b0000, NSQ, 1, OK, 4'b0000, 0, 1, 0, "R1 mask cleared");
      wait (sbq.size() == 0);
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule